// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block follows a processor core through its three power states, Run, Halt and Stop Grant, and drives the low-power requests that belong to each state. Decoded stop-clock messages move the core into and out of Stop Grant. A stop-clock request made while the core runs waits for an instruction boundary. A request made while the core is halted takes effect at once. Wake events bring a halted core back to Run. A release from Stop Grant returns the core to the state it held before entry.

While in Stop Grant, the block gates the core clock divisor on probe activity. While the link-stop input is held, it asks for memory self-refresh, a bridge clock ramp-down and a link width/frequency change. After a link stop, it blocks the stop-clock release until the link has been brought back up. The reset input, INIT and loss of power-good override everything else. Clock generation, the memory controller and link training sit outside the block.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst_n` is low, `pwr_ok` is low or `init_evt` is high at a clock edge, the state after that edge is Run and every request output is 0. This holds for as long as `pwr_ok` stays low, whatever the other inputs do.
- R2: `state_o` encodes Run as 2'b00, Halt as 2'b01 and Stop Grant as 2'b10. It never shows 2'b11.
- R3: In Run, `halt_req` without an instruction boundary moves the state to Halt on the next edge.
- R4: In Halt, `nmi_evt`, `smi_evt` or any bit of `irq_vec` moves the state to Run on the next edge. A wake wins over a stop-clock assert in the same cycle.
- R5: In Halt, `stpclk_on` with no wake moves the state to Stop Grant on the next edge, and `sg_cycle` is high for that one cycle.
- R6: In Run, a stop-clock assert is held pending until `instr_bnd`. The state reaches Stop Grant, with `sg_cycle`, only on the edge that samples `instr_bnd` with the request present or pending. If the core halts first, a pending request enters Stop Grant one edge after Halt is reached.
- R7: In Stop Grant, with no link hold, `stpclk_off` returns the state on the next edge to Halt if Stop Grant was entered from Halt, and to Run otherwise.
- R8: `clk_div_en` is 1 exactly when the state after an edge is Stop Grant and `probe_act` was 0 at that edge. It is therefore lifted one cycle after a probe starts and reapplied one cycle after it ends.
- R9: In Stop Grant, `mem_selfref_req`, `bridge_ramp_req` and `link_chg_req` follow `ldt_stop` with a one-cycle delay. All three drop one cycle after `ldt_stop` falls.
- R10: Once `ldt_stop` has been seen in Stop Grant, `stpclk_off` has no effect until `ldt_stop` is low and `link_reinit_done` has been sampled. A release is accepted from the following cycle on.
- R11: In Stop Grant, `stpclk_on`, `halt_req` and the wake inputs change nothing: the state stays Stop Grant and no second `sg_cycle` appears.
- R12: `sg_cycle` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Reset request, active low, sampled on the clock |
| pwr_ok | input | 1 | Power-good level; low holds the block in Run |
| init_evt | input | 1 | INIT message strobe |
| nmi_evt | input | 1 | Non-maskable interrupt strobe |
| smi_evt | input | 1 | System-management interrupt strobe |
| irq_vec | input | NUM_IRQ | Unmasked interrupt flags |
| stpclk_on | input | 1 | Decoded stop-clock assert message strobe |
| stpclk_off | input | 1 | Decoded stop-clock deassert message strobe |
| instr_bnd | input | 1 | Instruction-boundary strobe |
| halt_req | input | 1 | Halt request from the core |
| probe_act | input | 1 | Snoop probe activity level |
| ldt_stop | input | 1 | Link-stop level, high means stopped |
| link_reinit_done | input | 1 | Link reinitialisation complete strobe |
| sg_cycle | output | 1 | One-cycle Stop Grant special-cycle pulse |
| clk_div_en | output | 1 | Core clock divisor enable |
| mem_selfref_req | output | 1 | Memory self-refresh request |
| bridge_ramp_req | output | 1 | Bridge clock ramp-down request |
| link_chg_req | output | 1 | Link width/frequency change request |
| state_o | output | 2 | Current power state |

## Verification
Every output is registered, so each result is due one edge after the inputs that cause it. The one case that takes two edges is a pending stop-clock request carried into Halt, which lands one edge later. Inputs are applied at the falling edge. The bench records the expected state and outputs for that cycle in a queue, and a monitor compares them 2 ns after the next rising edge. Each expectation therefore meets exactly the edge that consumed its inputs. Sequences built from several cycles, such as the gated release after a link stop, are checked cycle by cycle, so an early or a late transition shows up in the cycle where it occurs.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'b00,
      PS_HALT = 2'b01,
      PS_SGNT = 2'b10
   } pstate_t;

   localparam int STATE_W   = 2;
   localparam int LINKREQ_N = 3;
   localparam int REQ_SELF  = 0;
   localparam int REQ_BRDG  = 1;
   localparam int REQ_LINK  = 2;

endpackage

// File: rtl/pss_event_dec.sv
module pss_event_dec #(
   parameter int NUM_IRQ = 4
) (
   input  logic               rst_n,
   input  logic               pwr_ok,
   input  logic               init_evt,
   input  logic               nmi_evt,
   input  logic               smi_evt,
   input  logic [NUM_IRQ-1:0] irq_vec,
   output logic               force_o,
   output logic               wake_o
);

   logic irq_any;

   generate
      if (NUM_IRQ < 1) begin : g_bad
         $error("pss_event_dec: NUM_IRQ must be at least 1");
      end
      if (NUM_IRQ == 1) begin : g_single
         assign irq_any = irq_vec[0];
      end else begin : g_multi
         logic [NUM_IRQ-1:0] acc;
         for (genvar i = 0; i < NUM_IRQ; i++) begin : g_or
            if (i == 0) begin : g_first
               assign acc[i] = irq_vec[i];
            end else begin : g_next
               assign acc[i] = acc[i-1] | irq_vec[i];
            end
         end
         assign irq_any = acc[NUM_IRQ-1];
      end
   endgenerate

   // reset, power loss and INIT dominate every other event
   assign force_o = !rst_n || !pwr_ok || init_evt;
   assign wake_o  = nmi_evt || smi_evt || irq_any;

endmodule

// File: rtl/pss_state_core.sv
module pss_state_core
   import pss_pkg::*;
(
   input  logic    clk,
   input  logic    force_i,
   input  logic    wake_i,
   input  logic    stpclk_on,
   input  logic    stpclk_off,
   input  logic    instr_bnd,
   input  logic    halt_req,
   input  logic    release_ok,
   output pstate_t state_q,
   output pstate_t state_nxt,
   output logic    sg_pulse_q
);

   logic pend_q, pend_d;
   logic from_halt_q, from_halt_d;
   logic enter_sg;
   logic stop_req;

   // a live request, or a pending one not cancelled this cycle
   assign stop_req = stpclk_on || (pend_q && !stpclk_off);

   always_comb begin
      state_nxt   = state_q;
      pend_d      = pend_q;
      from_halt_d = from_halt_q;
      enter_sg    = 1'b0;
      unique case (state_q)
         PS_RUN: begin
            if (stpclk_on)       pend_d = 1'b1;
            else if (stpclk_off) pend_d = 1'b0;
            if (stop_req && instr_bnd) begin
               state_nxt   = PS_SGNT;
               from_halt_d = 1'b0;
               pend_d      = 1'b0;
               enter_sg    = 1'b1;
            end else if (halt_req) begin
               state_nxt = PS_HALT;
            end
         end
         PS_HALT: begin
            if (wake_i) begin
               state_nxt = PS_RUN;
               if (stpclk_on)       pend_d = 1'b1;
               else if (stpclk_off) pend_d = 1'b0;
            end else if (stop_req) begin
               state_nxt   = PS_SGNT;
               from_halt_d = 1'b1;
               pend_d      = 1'b0;
               enter_sg    = 1'b1;
            end else if (stpclk_off) begin
               pend_d = 1'b0;
            end
         end
         PS_SGNT: begin
            if (stpclk_off && release_ok)
               state_nxt = from_halt_q ? PS_HALT : PS_RUN;
         end
         default: begin
            state_nxt = PS_RUN;
            pend_d    = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (force_i) begin
         state_q     <= PS_RUN;
         pend_q      <= 1'b0;
         from_halt_q <= 1'b0;
         sg_pulse_q  <= 1'b0;
      end else begin
         state_q     <= state_nxt;
         pend_q      <= pend_d;
         from_halt_q <= from_halt_d;
         sg_pulse_q  <= enter_sg;
      end
   end

endmodule

// File: rtl/pss_link_ctl.sv
module pss_link_ctl
   import pss_pkg::*;
(
   input  logic                 clk,
   input  logic                 force_i,
   input  pstate_t              state_q,
   input  pstate_t              state_nxt,
   input  logic                 ldt_stop,
   input  logic                 reinit_done,
   input  logic                 probe_act,
   output logic                 release_ok,
   output logic                 reinit_pend_q,
   output logic                 div_en_q,
   output logic [LINKREQ_N-1:0] req_q
);

   logic in_sg;
   logic req_set;

   assign in_sg      = (state_q == PS_SGNT);
   assign req_set    = in_sg && ldt_stop;
   assign release_ok = !ldt_stop && !reinit_pend_q;

   // sticky until the link reports it is back up after link-stop fell
   always_ff @(posedge clk) begin
      if (force_i)
         reinit_pend_q <= 1'b0;
      else if (req_set)
         reinit_pend_q <= 1'b1;
      else if (!ldt_stop && reinit_done)
         reinit_pend_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (force_i)
         div_en_q <= 1'b0;
      else
         div_en_q <= (state_nxt == PS_SGNT) && !probe_act;
   end

   generate
      for (genvar k = 0; k < LINKREQ_N; k++) begin : g_req
         always_ff @(posedge clk) begin
            if (force_i) req_q[k] <= 1'b0;
            else         req_q[k] <= req_set;
         end
      end
   endgenerate

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
   import pss_pkg::*;
#(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_ok,
   input  logic               init_evt,
   input  logic               nmi_evt,
   input  logic               smi_evt,
   input  logic [NUM_IRQ-1:0] irq_vec,
   input  logic               stpclk_on,
   input  logic               stpclk_off,
   input  logic               instr_bnd,
   input  logic               halt_req,
   input  logic               probe_act,
   input  logic               ldt_stop,
   input  logic               link_reinit_done,
   output logic               sg_cycle,
   output logic               clk_div_en,
   output logic               mem_selfref_req,
   output logic               bridge_ramp_req,
   output logic               link_chg_req,
   output logic [1:0]         state_o
);

   logic                 force_w;
   logic                 wake_w;
   logic                 release_ok;
   logic                 reinit_pend;
   logic [LINKREQ_N-1:0] req_w;
   pstate_t              state_q;
   pstate_t              state_nxt;

   pss_event_dec #(.NUM_IRQ(NUM_IRQ)) u_dec (
      .rst_n    (rst_n),
      .pwr_ok   (pwr_ok),
      .init_evt (init_evt),
      .nmi_evt  (nmi_evt),
      .smi_evt  (smi_evt),
      .irq_vec  (irq_vec),
      .force_o  (force_w),
      .wake_o   (wake_w)
   );

   pss_state_core u_core (
      .clk        (clk),
      .force_i    (force_w),
      .wake_i     (wake_w),
      .stpclk_on  (stpclk_on),
      .stpclk_off (stpclk_off),
      .instr_bnd  (instr_bnd),
      .halt_req   (halt_req),
      .release_ok (release_ok),
      .state_q    (state_q),
      .state_nxt  (state_nxt),
      .sg_pulse_q (sg_cycle)
   );

   pss_link_ctl u_link (
      .clk           (clk),
      .force_i       (force_w),
      .state_q       (state_q),
      .state_nxt     (state_nxt),
      .ldt_stop      (ldt_stop),
      .reinit_done   (link_reinit_done),
      .probe_act     (probe_act),
      .release_ok    (release_ok),
      .reinit_pend_q (reinit_pend),
      .div_en_q      (clk_div_en),
      .req_q         (req_w)
   );

   assign mem_selfref_req = req_w[REQ_SELF];
   assign bridge_ramp_req = req_w[REQ_BRDG];
   assign link_chg_req    = req_w[REQ_LINK];
   assign state_o         = state_q;

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int NUM_IRQ = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pwr_ok,
   input logic               init_evt,
   input logic               nmi_evt,
   input logic               smi_evt,
   input logic [NUM_IRQ-1:0] irq_vec,
   input logic               stpclk_on,
   input logic               stpclk_off,
   input logic               instr_bnd,
   input logic               halt_req,
   input logic               probe_act,
   input logic               ldt_stop,
   input logic               reinit_pend,
   input logic               sg_cycle,
   input logic               clk_div_en,
   input logic               mem_selfref_req,
   input logic               bridge_ramp_req,
   input logic               link_chg_req,
   input logic [1:0]         state_o
);

   localparam logic [1:0] S_RUN  = 2'b00;
   localparam logic [1:0] S_HALT = 2'b01;
   localparam logic [1:0] S_SG   = 2'b10;

   logic frc, wake;
   assign frc  = !pwr_ok || init_evt;
   assign wake = nmi_evt || smi_evt || (|irq_vec);

   p_force_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frc |=> (state_o == S_RUN) && !sg_cycle && !clk_div_en
              && !mem_selfref_req && !bridge_ramp_req && !link_chg_req);

   p_legal_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'b11);

   p_halt_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_RUN) && halt_req && !instr_bnd && !frc |=> state_o == S_HALT);

   p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_HALT) && wake && !frc |=> state_o == S_RUN);

   p_halt_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_HALT) && stpclk_on && !wake && !frc |=> (state_o == S_SG) && sg_cycle);

   p_run_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_RUN) && !instr_bnd && !frc |=> state_o != S_SG);

   p_bnd_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_RUN) && stpclk_on && instr_bnd && !frc |=> (state_o == S_SG) && sg_cycle);

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SG) && stpclk_off && !ldt_stop && !reinit_pend && !frc |=> state_o != S_SG);

   p_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_div_en |-> (state_o == S_SG) && !$past(probe_act));

   p_link_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SG) && ldt_stop && !frc |=> mem_selfref_req && bridge_ramp_req && link_chg_req);

   p_link_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_selfref_req |-> (state_o == S_SG) && $past(ldt_stop));

   p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SG) && (ldt_stop || reinit_pend) && !frc |=> state_o == S_SG);

   p_no_repeat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_SG) && !stpclk_off && !frc |=> (state_o == S_SG) && !sg_cycle);

   p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sg_cycle |=> !sg_cycle);

endmodule

bind pwr_state_seq pss_checker #(.NUM_IRQ(NUM_IRQ)) u_pss_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .pwr_ok          (pwr_ok),
   .init_evt        (init_evt),
   .nmi_evt         (nmi_evt),
   .smi_evt         (smi_evt),
   .irq_vec         (irq_vec),
   .stpclk_on       (stpclk_on),
   .stpclk_off      (stpclk_off),
   .instr_bnd       (instr_bnd),
   .halt_req        (halt_req),
   .probe_act       (probe_act),
   .ldt_stop        (ldt_stop),
   .reinit_pend     (reinit_pend),
   .sg_cycle        (sg_cycle),
   .clk_div_en      (clk_div_en),
   .mem_selfref_req (mem_selfref_req),
   .bridge_ramp_req (bridge_ramp_req),
   .link_chg_req    (link_chg_req),
   .state_o         (state_o)
);

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;

   localparam int NIRQ = 4;
   localparam logic [1:0] RUN = 2'b00, HLT = 2'b01, SG = 2'b10;

   typedef struct {
      logic [6:0] exp;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n, pwr_ok, init_evt, nmi_evt, smi_evt;
   logic [NIRQ-1:0] irq_vec;
   logic stpclk_on, stpclk_off, instr_bnd, halt_req, probe_act, ldt_stop, reinit_done;
   logic sg_cycle, clk_div_en, mem_selfref_req, bridge_ramp_req, link_chg_req;
   logic [1:0] state_o;

   item_t sb[$];
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_state_seq #(.NUM_IRQ(NIRQ)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .init_evt(init_evt),
      .nmi_evt(nmi_evt), .smi_evt(smi_evt), .irq_vec(irq_vec),
      .stpclk_on(stpclk_on), .stpclk_off(stpclk_off), .instr_bnd(instr_bnd),
      .halt_req(halt_req), .probe_act(probe_act), .ldt_stop(ldt_stop),
      .link_reinit_done(reinit_done), .sg_cycle(sg_cycle), .clk_div_en(clk_div_en),
      .mem_selfref_req(mem_selfref_req), .bridge_ramp_req(bridge_ramp_req),
      .link_chg_req(link_chg_req), .state_o(state_o)
   );

   // expected = {state, sg_cycle, clk_div_en, self-refresh, bridge, link}
   task automatic cyc(input string tag, input logic [1:0] st, input logic [4:0] o);
      item_t it;
      it.exp = {st, o};
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      stpclk_on = 0; stpclk_off = 0; instr_bnd = 0; halt_req = 0;
      init_evt = 0; nmi_evt = 0; smi_evt = 0; irq_vec = '0; reinit_done = 0;
   endtask

   // monitor: one expectation per rising edge, sampled 2 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it  = sb.pop_front();
            act = {state_o, sg_cycle, clk_div_en, mem_selfref_req, bridge_ramp_req, link_chg_req};
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; pwr_ok = 1; init_evt = 0; nmi_evt = 0; smi_evt = 0; irq_vec = '0;
      stpclk_on = 0; stpclk_off = 0; instr_bnd = 0; halt_req = 0;
      probe_act = 0; ldt_stop = 0; reinit_done = 0;
      @(negedge clk);
      halt_req = 1; cyc("R1 reset holds run", RUN, 5'b00000);
      cyc("R1 reset idle", RUN, 5'b00000);
      rst_n = 1;
      cyc("R1 idle after reset", RUN, 5'b00000);
      // halt and the wake sources
      halt_req = 1;  cyc("R3 run to halt", HLT, 5'b00000);
      nmi_evt = 1;   cyc("R4 nmi wake", RUN, 5'b00000);
      halt_req = 1;  cyc("R3 halt again", HLT, 5'b00000);
      smi_evt = 1;   cyc("R4 smi wake", RUN, 5'b00000);
      halt_req = 1;  cyc("R3 halt third", HLT, 5'b00000);
      irq_vec = 4'b0100; stpclk_on = 1; cyc("R4 irq wake beats stop", RUN, 5'b00000);
      instr_bnd = 1; cyc("R6 pending enters at boundary", SG, 5'b11000);
      stpclk_off = 1; cyc("R7 release to run", RUN, 5'b00000);
      // halt -> stop grant
      halt_req = 1;  cyc("R3 halt", HLT, 5'b00000);
      stpclk_on = 1; cyc("R5 halt stop grant", SG, 5'b11000);
      cyc("R12 pulse single", SG, 5'b01000);
      stpclk_on = 1; cyc("R11 repeat assert ignored", SG, 5'b01000);
      nmi_evt = 1; halt_req = 1; cyc("R11 wake ignored in sg", SG, 5'b01000);
      probe_act = 1; cyc("R8 probe lifts divisor", SG, 5'b00000);
      cyc("R8 probe held", SG, 5'b00000);
      probe_act = 0; cyc("R8 divisor back", SG, 5'b01000);
      stpclk_off = 1; cyc("R7 release to halt", HLT, 5'b00000);
      nmi_evt = 1; cyc("R4 wake", RUN, 5'b00000);
      // run -> stop grant waits for boundary
      stpclk_on = 1; cyc("R6 no boundary stays run", RUN, 5'b00000);
      cyc("R6 still run", RUN, 5'b00000);
      instr_bnd = 1; cyc("R6 boundary enters", SG, 5'b11000);
      // link stop gating
      ldt_stop = 1; cyc("R9 link requests on", SG, 5'b01111);
      stpclk_off = 1; cyc("R10 release blocked by link stop", SG, 5'b01111);
      ldt_stop = 0; cyc("R9 link requests off", SG, 5'b01000);
      stpclk_off = 1; cyc("R10 release blocked pending reinit", SG, 5'b01000);
      reinit_done = 1; cyc("R10 reinit seen", SG, 5'b01000);
      stpclk_off = 1; cyc("R7 release after reinit", RUN, 5'b00000);
      // pending request carried into halt
      stpclk_on = 1; cyc("R6 pending set", RUN, 5'b00000);
      halt_req = 1;  cyc("R3 halt with pending", HLT, 5'b00000);
      cyc("R6 pending enters from halt", SG, 5'b11000);
      // forced exits
      ldt_stop = 1; cyc("R9 requests", SG, 5'b01111);
      init_evt = 1; cyc("R1 init forces run", RUN, 5'b00000);
      ldt_stop = 0;
      halt_req = 1; cyc("R3 halt", HLT, 5'b00000);
      stpclk_on = 1; cyc("R5 stop grant", SG, 5'b11000);
      pwr_ok = 0; cyc("R1 power loss forces run", RUN, 5'b00000);
      halt_req = 1; cyc("R1 power loss holds", RUN, 5'b00000);
      stpclk_on = 1; instr_bnd = 1; cyc("R1 power loss holds stop", RUN, 5'b00000);
      pwr_ok = 1; halt_req = 1; cyc("R2 halt code 01", HLT, 5'b00000);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule